// File: doc/BRIEF.md
# Self Refresh Entry and Exit Sequencer

This block sits beside the main command scheduler of a DRAM controller and takes the device into its low-power self refresh state and back out. The scheduler raises an entry request. The sequencer waits until every bank reports idle, then parks the termination line low. It issues a REFRESH command in the same cycle that it pulls the clock-enable line low, and follows it with one NOP. From that point the device keeps its own contents refreshed. The sequencer tells the clocking logic when the memory clock may be stopped. When the exit request comes, it restores a stable clock, raises clock-enable and holds back traffic until two recovery windows have passed. The first window covers ordinary commands and the second covers commands that rely on a locked DLL.

Every interval is a cycle count supplied on a configuration input and held static while a sequence runs. A mode input tells the block that the memory clock will be stopped during self refresh. When it is clear, the clock-stop waits are skipped and only the minimum clock-enable-low time applies. A second mode input tells the block that termination is disabled. The termination-off wait before entry is then skipped.

Top module: `sr_seq`

## Requirements
- R1: Out of reset and while idle, `dram_cke` is 1 and `dram_cmd` is NOP. The command encoding is {RAS#,CAS#,WE#}, with NOP = 3'b111 and REFRESH = 3'b001. `dram_odt` follows `odt_req`. Both ready flags are 1, and `clk_stop_ok` and `enter_ack` are 0.
- R2: An entry request made while `banks_idle` is 0 is kept pending. No REFRESH is issued and `dram_cke` stays 1 until `banks_idle` is 1, and then entry proceeds without a new request.
- R3: With `cfg_rtt_off` = 0, `dram_odt` is 0 for exactly `cfg_t_odt`+1 cycles before the REFRESH cycle. With `cfg_rtt_off` = 1, the REFRESH follows the check cycle directly and no extra ODT-low cycle comes before it.
- R4: REFRESH is driven for exactly one cycle with `dram_cke` 0. The next cycle carries NOP with `dram_cke` 0, and `enter_ack` is high for that single cycle.
- R5: With the clock-stop mode clear and an exit request given in the acknowledge cycle, `dram_cke` stays low for max(`cfg_t_ckesr`,1)+2 cycles. In every case it stays low for more than `cfg_t_ckesr` cycles.
- R6: An exit request that comes before the minimum low time has passed is latched and acted on later. An exit request while not in self refresh is ignored and does not end a later self refresh. In self refresh with the minimum met and the clock-stop mode clear, `dram_cke` rises two cycles after the request cycle.
- R7: With the clock-stop mode set, `clk_stop_ok` first rises max(`cfg_t_cksre`+1,2) cycles after the REFRESH cycle. It falls exactly `cfg_t_cksrx`+1 cycles before `dram_cke` rises. With an early exit, `dram_cke` stays low for max(`cfg_t_ckesr`+1,`cfg_t_cksre`+1,2)+`cfg_t_cksrx`+2 cycles.
- R8: Take the cycle in which `dram_cke` returns high as cycle 0. `rdy_nodll` rises in cycle `cfg_t_xs`+1 and `rdy_dll` rises in cycle max(`cfg_t_xs`,`cfg_t_xsdll`)+1. `rdy_dll` never stands without `rdy_nodll`.
- R9: From the cycle after REFRESH until `rdy_dll` returns, `dram_cmd` is NOP in every cycle.
- R10: With the clock-stop mode clear, `clk_stop_ok` stays 0 for the whole sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enter_req | input | 1 | Entry request from the scheduler, accepted when idle |
| enter_ack | output | 1 | One-cycle pulse once the device is in self refresh |
| exit_req | input | 1 | Exit request, latched while in self refresh |
| banks_idle | input | 1 | All banks precharged, precharge recovery met, no burst active |
| odt_req | input | 1 | Termination value from the scheduler, passed through when idle |
| cfg_rtt_off | input | 1 | Termination disabled, so the ODT-off wait is skipped |
| cfg_clk_stop | input | 1 | Memory clock will be stopped during self refresh |
| cfg_t_odt | input | CNT_W | Extra ODT-low cycles before entry |
| cfg_t_cksre | input | CNT_W | Cycles after entry before the clock may stop |
| cfg_t_cksrx | input | CNT_W | Stable-clock cycles required before exit |
| cfg_t_ckesr | input | CNT_W | Minimum clock-enable-low cycles |
| cfg_t_xs | input | CNT_W | Exit recovery for commands that do not need the DLL |
| cfg_t_xsdll | input | CNT_W | Exit recovery for commands that need a locked DLL |
| dram_cmd | output | 3 | Command {RAS#,CAS#,WE#} |
| dram_cke | output | 1 | Clock enable to the device |
| dram_odt | output | 1 | Termination control to the device |
| clk_stop_ok | output | 1 | Memory clock may be stopped or changed |
| rdy_nodll | output | 1 | Commands not needing a locked DLL may be issued |
| rdy_dll | output | 1 | Commands needing a locked DLL may be issued |

## Verification
The bench aims at the places where a one-cycle slip hides. The first is the ODT-low run before REFRESH: a design that moved the termination late would show too few low cycles. The second is the clock-enable-low length when the exit request arrives early. A design that dropped the early request would hang in self refresh, and one that ignored the minimum would raise clock-enable too soon. The bench also checks the gap between the clock-stop permission falling and clock-enable rising, which exposes a missing or short restore wait. It checks the two ready flags, including the case where the DLL window is shorter than the other, which catches a design that chains the windows instead of running them side by side. It also covers an entry held back by busy banks, and an exit request made while idle that must not end a later self refresh.

// File: rtl/sr_pkg.sv
package sr_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_CHECK,
      ST_ODT_OFF,
      ST_SRE_ISSUE,
      ST_SRE_NOP,
      ST_IN_SR,
      ST_CLK_RESTORE_WAIT,
      ST_EXIT_CKE_HIGH,
      ST_WAIT_XS,
      ST_WAIT_XSDLL
   } sr_state_e;

   typedef enum logic [1:0] {
      PH_ODT,
      PH_SRE,
      PH_SRX
   } phase_sel_e;

   localparam logic [2:0] CMD_NOP = 3'b111;
   localparam logic [2:0] CMD_REF = 3'b001;

   localparam int TMR_PHASE = 0;
   localparam int TMR_CKESR = 1;
   localparam int TMR_XS    = 2;
   localparam int TMR_XSDLL = 3;
   localparam int NUM_TMR   = 4;

endpackage

// File: rtl/sr_timer.sv
module sr_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         done
);

   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign done = (cnt == '0);

   // R5: an expired timer stays expired until reloaded
   assert_hold_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt == '0) |=> (cnt == '0));

   // R5: a running timer steps down by one per cycle
   assert_step_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/sr_fsm.sv
module sr_fsm
   import sr_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enter_req,
   input  logic               exit_req,
   input  logic               banks_idle,
   input  logic               odt_req,
   input  logic               rtt_off,
   input  logic               stop_mode,
   input  logic [NUM_TMR-1:0] tmr_done,
   output logic [NUM_TMR-1:0] tmr_load,
   output phase_sel_e         phase_sel,
   output logic [2:0]         dram_cmd,
   output logic               dram_cke,
   output logic               dram_odt,
   output logic               clk_stop_ok,
   output logic               enter_ack,
   output logic               rdy_nodll,
   output logic               rdy_dll
);

   sr_state_e state, nxt;
   logic      exit_pend;
   logic      in_sr_window;
   logic      leave_sr;
   logic      before_entry;
   logic      in_recovery;

   assign in_sr_window = (state == ST_SRE_ISSUE) || (state == ST_SRE_NOP) || (state == ST_IN_SR);
   assign leave_sr     = (state == ST_IN_SR) && exit_pend && tmr_done[TMR_CKESR] &&
                         (!stop_mode || tmr_done[TMR_PHASE]);
   assign before_entry = (state == ST_IDLE) || (state == ST_CHECK);
   assign in_recovery  = (state == ST_WAIT_XS) || (state == ST_WAIT_XSDLL);

   always_comb begin
      nxt       = state;
      tmr_load  = '0;
      phase_sel = PH_ODT;
      unique case (state)
         ST_IDLE:
            if (enter_req) nxt = ST_CHECK;
         ST_CHECK:
            if (banks_idle) begin
               if (rtt_off) begin
                  nxt = ST_SRE_ISSUE;
               end else begin
                  nxt                 = ST_ODT_OFF;
                  tmr_load[TMR_PHASE] = 1'b1;
                  phase_sel           = PH_ODT;
               end
            end
         ST_ODT_OFF:
            if (tmr_done[TMR_PHASE]) nxt = ST_SRE_ISSUE;
         ST_SRE_ISSUE: begin
            nxt                 = ST_SRE_NOP;
            tmr_load[TMR_PHASE] = 1'b1;
            tmr_load[TMR_CKESR] = 1'b1;
            phase_sel           = PH_SRE;
         end
         ST_SRE_NOP:
            nxt = ST_IN_SR;
         ST_IN_SR:
            if (leave_sr) begin
               if (stop_mode) begin
                  nxt                 = ST_CLK_RESTORE_WAIT;
                  tmr_load[TMR_PHASE] = 1'b1;
                  phase_sel           = PH_SRX;
               end else begin
                  nxt = ST_EXIT_CKE_HIGH;
               end
            end
         ST_CLK_RESTORE_WAIT:
            if (tmr_done[TMR_PHASE]) nxt = ST_EXIT_CKE_HIGH;
         ST_EXIT_CKE_HIGH: begin
            nxt                 = ST_WAIT_XS;
            tmr_load[TMR_XS]    = 1'b1;
            tmr_load[TMR_XSDLL] = 1'b1;
         end
         ST_WAIT_XS:
            if (tmr_done[TMR_XS]) nxt = ST_WAIT_XSDLL;
         ST_WAIT_XSDLL:
            if (tmr_done[TMR_XSDLL]) nxt = ST_IDLE;
         default:
            nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         exit_pend <= 1'b0;
      end else begin
         state <= nxt;
         if (leave_sr)
            exit_pend <= 1'b0;
         else if (exit_req && in_sr_window)
            exit_pend <= 1'b1;
      end
   end

   always_comb begin
      dram_cke    = !(in_sr_window || (state == ST_CLK_RESTORE_WAIT));
      dram_cmd    = (state == ST_SRE_ISSUE) ? CMD_REF : CMD_NOP;
      dram_odt    = before_entry ? odt_req : 1'b0;
      clk_stop_ok = (state == ST_IN_SR) && stop_mode && tmr_done[TMR_PHASE];
      enter_ack   = (state == ST_SRE_NOP);
      rdy_nodll   = before_entry || (in_recovery && tmr_done[TMR_XS]);
      rdy_dll     = before_entry ||
                    (in_recovery && tmr_done[TMR_XS] && tmr_done[TMR_XSDLL]);
   end

   // R2: a check with busy banks never yields a REFRESH next cycle
   assert_busy_blocks_ref_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CHECK && !banks_idle) |=> (dram_cmd != CMD_REF && dram_cke));

   // R3: termination already low in the cycle before REFRESH when it is in use
   assert_odt_low_before_ref_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (dram_cmd == CMD_REF && !rtt_off) |-> $past(!dram_odt));

   // R4: REFRESH is followed by a NOP with clock enable still low
   assert_nop_after_ref_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (dram_cmd == CMD_REF) |=> (dram_cmd == CMD_NOP && !dram_cke && enter_ack));

   // R9: the cycle after any clock-enable-low cycle carries no REFRESH unless it is entry
   assert_no_repeat_ref_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!dram_cke && dram_cmd != CMD_REF) |=> (dram_cmd == CMD_NOP));

endmodule

// File: rtl/sr_seq.sv
module sr_seq
   import sr_pkg::*;
#(
   parameter int CNT_W            = 8,
   parameter bit CLK_STOP_SUPPORT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enter_req,
   output logic             enter_ack,
   input  logic             exit_req,
   input  logic             banks_idle,
   input  logic             odt_req,
   input  logic             cfg_rtt_off,
   input  logic             cfg_clk_stop,
   input  logic [CNT_W-1:0] cfg_t_odt,
   input  logic [CNT_W-1:0] cfg_t_cksre,
   input  logic [CNT_W-1:0] cfg_t_cksrx,
   input  logic [CNT_W-1:0] cfg_t_ckesr,
   input  logic [CNT_W-1:0] cfg_t_xs,
   input  logic [CNT_W-1:0] cfg_t_xsdll,
   output logic [2:0]       dram_cmd,
   output logic             dram_cke,
   output logic             dram_odt,
   output logic             clk_stop_ok,
   output logic             rdy_nodll,
   output logic             rdy_dll
);

   localparam int RUN_W = CNT_W + 1;

   generate
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_width
         $error("sr_seq: CNT_W must lie between 2 and 16");
      end
   endgenerate

   logic stop_mode;

   generate
      if (CLK_STOP_SUPPORT) begin : g_stop
         assign stop_mode = cfg_clk_stop;
      end else begin : g_no_stop
         assign stop_mode = 1'b0;
      end
   endgenerate

   logic [NUM_TMR-1:0] tmr_load;
   logic [NUM_TMR-1:0] tmr_done;
   logic [CNT_W-1:0]   tmr_val [NUM_TMR];
   phase_sel_e         phase_sel;

   always_comb begin
      unique case (phase_sel)
         PH_SRE:  tmr_val[TMR_PHASE] = cfg_t_cksre;
         PH_SRX:  tmr_val[TMR_PHASE] = cfg_t_cksrx;
         default: tmr_val[TMR_PHASE] = cfg_t_odt;
      endcase
      tmr_val[TMR_CKESR] = cfg_t_ckesr;
      tmr_val[TMR_XS]    = cfg_t_xs;
      tmr_val[TMR_XSDLL] = cfg_t_xsdll;
   end

   generate
      for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
         sr_timer #(.W(CNT_W)) u_tmr (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (tmr_load[i]),
            .load_val (tmr_val[i]),
            .done     (tmr_done[i])
         );
      end
   endgenerate

   sr_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .enter_req   (enter_req),
      .exit_req    (exit_req),
      .banks_idle  (banks_idle),
      .odt_req     (odt_req),
      .rtt_off     (cfg_rtt_off),
      .stop_mode   (stop_mode),
      .tmr_done    (tmr_done),
      .tmr_load    (tmr_load),
      .phase_sel   (phase_sel),
      .dram_cmd    (dram_cmd),
      .dram_cke    (dram_cke),
      .dram_odt    (dram_odt),
      .clk_stop_ok (clk_stop_ok),
      .enter_ack   (enter_ack),
      .rdy_nodll   (rdy_nodll),
      .rdy_dll     (rdy_dll)
   );

   // run length of clock-enable-low cycles, observed for the minimum-low check
   logic [RUN_W-1:0] low_run;

   always_ff @(posedge clk) begin
      if (!rst_n)
         low_run <= '0;
      else if (dram_cke)
         low_run <= '0;
      else if (low_run != {RUN_W{1'b1}})
         low_run <= low_run + 1'b1;
   end

   // R5: clock enable never returns high before the minimum low time
   assert_ckesr_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dram_cke) |-> (low_run > {1'b0, cfg_t_ckesr}));

   // R7: the clock may only be stopped while clock enable is low
   assert_stop_needs_cke_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clk_stop_ok |-> !dram_cke);

   // R8: DLL-dependent readiness implies ordinary readiness
   assert_rdy_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rdy_dll |-> rdy_nodll);

   // R8: nothing is ready while the device is held in self refresh
   assert_no_rdy_in_sr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_cke |-> (!rdy_nodll && !rdy_dll));

   // R10: without the clock-stop mode the permission never rises
   assert_no_stop_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !stop_mode |-> !clk_stop_ok);

endmodule

// File: tb/sim_sr_seq.sv
module sim_sr_seq;
   import sr_pkg::*;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         enter_req = 1'b0, exit_req = 1'b0, banks_idle = 1'b1, odt_req = 1'b1;
   logic         cfg_rtt_off = 1'b0, cfg_clk_stop = 1'b0;
   logic [W-1:0] cfg_t_odt = '0, cfg_t_cksre = '0, cfg_t_cksrx = '0;
   logic [W-1:0] cfg_t_ckesr = '0, cfg_t_xs = '0, cfg_t_xsdll = '0;
   logic [2:0]   dram_cmd;
   logic         enter_ack, dram_cke, dram_odt, clk_stop_ok, rdy_nodll, rdy_dll;

   always #2 clk = ~clk;

   sr_seq #(.CNT_W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .enter_req(enter_req), .enter_ack(enter_ack),
      .exit_req(exit_req), .banks_idle(banks_idle), .odt_req(odt_req),
      .cfg_rtt_off(cfg_rtt_off), .cfg_clk_stop(cfg_clk_stop),
      .cfg_t_odt(cfg_t_odt), .cfg_t_cksre(cfg_t_cksre), .cfg_t_cksrx(cfg_t_cksrx),
      .cfg_t_ckesr(cfg_t_ckesr), .cfg_t_xs(cfg_t_xs), .cfg_t_xsdll(cfg_t_xsdll),
      .dram_cmd(dram_cmd), .dram_cke(dram_cke), .dram_odt(dram_odt),
      .clk_stop_ok(clk_stop_ok), .rdy_nodll(rdy_nodll), .rdy_dll(rdy_dll)
   );

   int n_chk  = 0;
   int n_fail = 0;

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   typedef struct packed {
      logic [7:0] t_odt, t_sre, t_srx, t_ckesr, t_xs, t_xsdll;
      logic       stop, rtt;
      logic [7:0] e_odt, e_low, e_nodll, e_dll;
   } vec_t;

   localparam int NV = 5;
   localparam vec_t VECS [NV] = '{
      '{8'd2, 8'd0, 8'd0, 8'd3, 8'd5, 8'd10, 1'b0, 1'b0, 8'd3, 8'd5,  8'd6, 8'd11},
      '{8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0,  1'b0, 1'b1, 8'd0, 8'd3,  8'd1, 8'd1},
      '{8'd1, 8'd4, 8'd2, 8'd2, 8'd3, 8'd3,  1'b1, 1'b0, 8'd2, 8'd9,  8'd4, 8'd4},
      '{8'd4, 8'd1, 8'd5, 8'd6, 8'd7, 8'd20, 1'b1, 1'b0, 8'd5, 8'd14, 8'd8, 8'd21},
      '{8'd3, 8'd0, 8'd0, 8'd1, 8'd2, 8'd1,  1'b1, 1'b1, 8'd0, 8'd4,  8'd3, 8'd3}
   };

   task automatic set_cfg(input vec_t v);
      cfg_t_odt = v.t_odt;     cfg_t_cksre = v.t_sre;  cfg_t_cksrx = v.t_srx;
      cfg_t_ckesr = v.t_ckesr; cfg_t_xs = v.t_xs;      cfg_t_xsdll = v.t_xsdll;
      cfg_clk_stop = v.stop;   cfg_rtt_off = v.rtt;
   endtask

   task automatic wait_ready();
      for (int k = 0; k < 300; k++) begin
         @(negedge clk);
         if (rdy_dll) break;
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic wait_ref();
      for (int k = 0; k < 300; k++) begin
         if (dram_cmd == CMD_REF) break;
         @(negedge clk);
      end
   endtask

   task automatic run_vec(input vec_t v, input int idx);
      int odt_low = 0, low = 0, t = 0, nodll = -1, dll = -1, bad_nop = 0, stray_stop = 0;
      @(negedge clk);
      set_cfg(v);
      odt_req = 1'b1; banks_idle = 1'b1; enter_req = 1'b1;
      @(negedge clk);
      enter_req = 1'b0;
      for (int k = 0; k < 300; k++) begin
         if (dram_cmd == CMD_REF) break;
         if (!dram_odt) odt_low++;
         @(negedge clk);
      end
      chk("R3", $sformatf("vec%0d odt-low cycles before REFRESH", idx), odt_low, v.e_odt);
      chk("R4", $sformatf("vec%0d cke at REFRESH", idx), dram_cke, 0);
      low = 1;
      @(negedge clk);
      chk("R4", $sformatf("vec%0d cmd after REFRESH", idx), dram_cmd, CMD_NOP);
      chk("R4", $sformatf("vec%0d enter_ack after REFRESH", idx), enter_ack, 1);
      chk("R4", $sformatf("vec%0d cke after REFRESH", idx), dram_cke, 0);
      low++;
      exit_req = 1'b1;
      for (int k = 0; k < 300; k++) begin
         @(negedge clk);
         exit_req = 1'b0;
         if (clk_stop_ok && !v.stop) stray_stop++;
         if (dram_cke) break;
         if (dram_cmd != CMD_NOP) bad_nop++;
         low++;
      end
      chk("R5", $sformatf("vec%0d cke-low cycles (early exit)", idx), low, v.e_low);
      for (int k = 0; k < 300; k++) begin
         @(negedge clk);
         t++;
         if (nodll < 0 && rdy_nodll) nodll = t;
         if (!rdy_dll && dram_cmd != CMD_NOP) bad_nop++;
         if (rdy_dll) begin
            dll = t;
            break;
         end
      end
      chk("R8", $sformatf("vec%0d rdy_nodll delay", idx), nodll, v.e_nodll);
      chk("R8", $sformatf("vec%0d rdy_dll delay", idx), dll, v.e_dll);
      chk("R9", $sformatf("vec%0d non-NOP cycles in sequence", idx), bad_nop, 0);
      if (!v.stop) chk("R10", $sformatf("vec%0d clk_stop_ok cycles", idx), stray_stop, 0);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int first, last_ok, gap, idxc;
      // reset state
      repeat (3) @(negedge clk);
      chk("R1", "cke in reset", dram_cke, 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "cke idle", dram_cke, 1);
      chk("R1", "cmd idle", dram_cmd, CMD_NOP);
      chk("R1", "odt follows request high", dram_odt, 1);
      chk("R1", "rdy_nodll idle", rdy_nodll, 1);
      chk("R1", "rdy_dll idle", rdy_dll, 1);
      chk("R1", "clk_stop_ok idle", clk_stop_ok, 0);
      chk("R1", "enter_ack idle", enter_ack, 0);
      odt_req = 1'b0;
      @(negedge clk);
      chk("R1", "odt follows request low", dram_odt, 0);
      odt_req = 1'b1;

      // table walk
      for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

      // R6: exit request in idle is ignored and not remembered
      @(negedge clk);
      set_cfg('{8'd1, 8'd0, 8'd0, 8'd3, 8'd2, 8'd4, 1'b0, 1'b0, 8'd0, 8'd0, 8'd0, 8'd0});
      exit_req = 1'b1;
      @(negedge clk);
      exit_req = 1'b0;
      @(negedge clk);
      chk("R6", "cke after idle exit request", dram_cke, 1);
      enter_req = 1'b1;
      @(negedge clk);
      enter_req = 1'b0;
      wait_ref();
      repeat (30) @(negedge clk);
      chk("R6", "still in self refresh without new exit request", dram_cke, 0);
      exit_req = 1'b1;
      @(negedge clk);
      exit_req = 1'b0;
      chk("R6", "cke one cycle after late exit", dram_cke, 0);
      @(negedge clk);
      chk("R6", "cke two cycles after late exit", dram_cke, 1);
      wait_ready();

      // R2: entry held while banks busy
      banks_idle = 1'b0;
      enter_req = 1'b1;
      @(negedge clk);
      enter_req = 1'b0;
      first = 0;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         if (dram_cmd == CMD_REF || !dram_cke) first++;
      end
      chk("R2", "REFRESH or cke-low while banks busy", first, 0);
      chk("R2", "odt untouched while banks busy", dram_odt, 1);
      banks_idle = 1'b1;
      first = -1;
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         if (dram_cmd == CMD_REF) begin
            first = 1;
            break;
         end
      end
      chk("R2", "pending entry proceeds once idle", first, 1);
      exit_req = 1'b1;
      @(negedge clk);
      exit_req = 1'b0;
      wait_ready();

      // R7: clock stop with late exit
      set_cfg('{8'd0, 8'd3, 8'd4, 8'd1, 8'd1, 8'd2, 1'b1, 1'b1, 8'd0, 8'd0, 8'd0, 8'd0});
      enter_req = 1'b1;
      @(negedge clk);
      enter_req = 1'b0;
      wait_ref();
      first = -1;
      idxc = 0;
      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         idxc++;
         if (clk_stop_ok && first < 0) first = idxc;
      end
      chk("R7", "clk_stop_ok first cycle after REFRESH", first, 4);
      exit_req = 1'b1;
      last_ok = idxc;
      gap = -1;
      for (int k = 0; k < 100; k++) begin
         @(negedge clk);
         exit_req = 1'b0;
         idxc++;
         if (clk_stop_ok) last_ok = idxc;
         if (dram_cke) begin
            gap = idxc - last_ok - 1;
            break;
         end
      end
      chk("R7", "stable-clock cycles before cke rises", gap, 5);
      wait_ready();

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule